// File: doc/BRIEF.md
# Multi-Modulus Divider Control Sequencer

This block divides an input clock, the divide-by-2 output of a synthesizer, by a modulus M that can change every output cycle. It models a 4/5 dual-modulus prescaler as a counter and steers its select line. Each output cycle opens with five divide-by-4 prescaler periods (20 input periods). The remaining M-20 input periods are then split by a closed-form rule into a number of divide-by-4 periods followed by a number of divide-by-5 periods.

A pass strobe marks the final prescaler period of a cycle. An edge-select register captures it on the next prescaler boundary, and a resynchronization register retimes that onto the input clock to form the divider output. The modulus input is captured at a fixed delay after each output rising edge. That instant falls inside the opening run, so the new modulus governs the cycle that is already under way. A modulus that cannot be built from the opening run plus whole 4 and 5 periods is clamped, and an error flag is raised.

Top module: `mmd_ctrl`

## Requirements
- R1: While rst_ni is low and right after it rises, div_o, psel_o, ppass_o, ld_o and err_o are all 0.
- R2: A prescaler period lasts 4 input cycles while psel_o is low and 5 while it is high, so the low-select cycles in an output cycle number 20 + 4*m4.
- R3: psel_o is low during the first 20 input cycles of every output cycle, which covers the fixed run of five divide-by-4 periods.
- R4: With d = M-20, the cycle uses m5 = d mod 4 divide-by-5 periods and m4 = floor(d/4) - m5 divide-by-4 periods after the opening run; psel_o is high for exactly 5*m5 input cycles per output cycle.
- R5: For a valid M, the distance between consecutive rising edges of div_o is exactly M input cycles.
- R6: ppass_o is high for the whole last prescaler period of each cycle (5 cycles if m5 > 0, else 4), and div_o rises one cycle after ppass_o falls.
- R7: div_o stays high for 4 input cycles after each rising edge; it rises one input cycle after the prescaler boundary that ends the cycle.
- R8: ld_o pulses for one cycle, and mod_i is captured on the 15th rising clock edge after the edge that raised div_o (ld_o is high in the cycle before that capture).
- R9: M is valid when M >= 20 and floor(d/4) >= d mod 4. M < 20 is treated as 20; otherwise an invalid M is treated as 20 + 5*floor(d/4). err_o changes only at a capture and then shows whether the captured M was clamped.
- R10: After reset, the first output cycle uses M = 20, so div_o first rises 21 clock edges after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock (divide-by-2 output) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mod_i | input | MOD_W | Requested modulus M for the coming cycle |
| div_o | output | 1 | Divider output, retimed to clk_i |
| psel_o | output | 1 | Prescaler select, 1 selects divide-by-5 |
| ppass_o | output | 1 | High during the final prescaler period of a cycle |
| ld_o | output | 1 | One-cycle strobe before mod_i is captured |
| err_o | output | 1 | Captured modulus was clamped |

## Verification
The modulus capture and the start of the final prescaler period can fall on the same cycle. When M is 20, the freshly captured split must decide at once that the fifth opening period is the last one. Otherwise the pass strobe would come a cycle late or not at all. This is provoked by a sweep over every modulus from 0 upward, which includes 20 to 23 and the clamped values, and by long alternations between 20 and the largest modulus. It is judged through the edge spacing and the width of the pass strobe in each window.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int OPEN_PERIODS = 5;
  localparam int PRE_LO       = 4;
  localparam int PRE_HI       = 5;
  localparam int BASE_LEN     = OPEN_PERIODS * PRE_LO;

  typedef enum logic [1:0] {
    SEG_OPEN,
    SEG_DIV4,
    SEG_DIV5
  } seg_e;
endpackage

// File: rtl/mmd_prescaler.sv
module mmd_prescaler
  import mmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic psel_i,
  output logic tick_o
);
  localparam int PW = $clog2(PRE_HI);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] last;

  assign last   = psel_i ? PW'(PRE_HI - 1) : PW'(PRE_LO - 1);
  assign tick_o = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/mmd_split.sv
module mmd_split
  import mmd_pkg::*;
#(
  parameter int MOD_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic [MOD_W-1:0] m4_o,
  output logic [MOD_W-1:0] m5_o,
  output logic             err_o
);
  logic [MOD_W-1:0] d, q, r, m4_n, m5_n;
  logic             err_n;

  always_comb begin
    err_n = 1'b0;
    d     = '0;
    if (mod_i < MOD_W'(BASE_LEN)) err_n = 1'b1;
    else                          d     = mod_i - MOD_W'(BASE_LEN);
    q = d >> 2;
    r = {{(MOD_W-2){1'b0}}, d[1:0]};
    // too few quarters to absorb the remainder: drop it to q
    if (r > q) begin
      err_n = 1'b1;
      r     = q;
    end
    m5_n = r;
    m4_n = q - r;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m4_o  <= '0;
      m5_o  <= '0;
      err_o <= 1'b0;
    end else if (ld_i) begin
      m4_o  <= m4_n;
      m5_o  <= m5_n;
      err_o <= err_n;
    end
  end
endmodule

// File: rtl/mmd_seq.sv
module mmd_seq
  import mmd_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] m4_i,
  input  logic [CNT_W-1:0] m5_i,
  output logic             psel_o,
  output logic             ppass_o
);
  seg_e             seg_q;
  logic [CNT_W-1:0] left_q;
  logic             last_seg;

  always_comb begin
    unique case (seg_q)
      SEG_DIV5: last_seg = 1'b1;
      SEG_DIV4: last_seg = (m5_i == '0);
      default:  last_seg = (m4_i == '0) && (m5_i == '0);
    endcase
  end

  assign ppass_o = last_seg && (left_q == '0);
  assign psel_o  = (seg_q == SEG_DIV5);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= SEG_OPEN;
      left_q <= CNT_W'(OPEN_PERIODS - 1);
    end else if (tick_i) begin
      if (ppass_o) begin
        seg_q  <= SEG_OPEN;
        left_q <= CNT_W'(OPEN_PERIODS - 1);
      end else if (left_q != '0) begin
        left_q <= left_q - CNT_W'(1);
      end else if (seg_q == SEG_OPEN && m4_i != '0) begin
        seg_q  <= SEG_DIV4;
        left_q <= m4_i - CNT_W'(1);
      end else begin
        seg_q  <= SEG_DIV5;
        left_q <= m5_i - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/mmd_edge.sv
module mmd_edge #(
  parameter int LOAD_DLY = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ppass_i,
  output logic div_o,
  output logic ld_o
);
  localparam int DW = $clog2(LOAD_DLY + 1);

  logic          es_q, div_q, div_d;
  logic [DW-1:0] dly_q;
  logic          rise;

  assign rise  = div_q & ~div_d;
  assign div_o = div_q;
  assign ld_o  = (dly_q == DW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      es_q  <= 1'b0;
      div_q <= 1'b0;
      div_d <= 1'b0;
      dly_q <= '0;
    end else begin
      if (tick_i) es_q <= ppass_i;
      div_q <= es_q;
      div_d <= div_q;
      if (rise)             dly_q <= DW'(LOAD_DLY - 1);
      else if (dly_q != '0) dly_q <= dly_q - DW'(1);
    end
  end
endmodule

// File: rtl/mmd_ctrl.sv
module mmd_ctrl
  import mmd_pkg::*;
#(
  parameter int MOD_W    = 7,
  parameter int LOAD_DLY = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MOD_W-1:0] mod_i,
  output logic             div_o,
  output logic             psel_o,
  output logic             ppass_o,
  output logic             ld_o,
  output logic             err_o
);
  localparam int CNT_W = MOD_W;

  logic             tick;
  logic [CNT_W-1:0] m4, m5;

  mmd_prescaler u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .psel_i(psel_o),
    .tick_o(tick)
  );

  mmd_split #(.MOD_W(MOD_W)) u_split (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (ld_o),
    .mod_i (mod_i),
    .m4_o  (m4),
    .m5_o  (m5),
    .err_o (err_o)
  );

  mmd_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .m4_i   (m4),
    .m5_i   (m5),
    .psel_o (psel_o),
    .ppass_o(ppass_o)
  );

  mmd_edge #(.LOAD_DLY(LOAD_DLY)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .ppass_i(ppass_o),
    .div_o  (div_o),
    .ld_o   (ld_o)
  );
endmodule

// File: rtl/mmd_ctrl_chk.sv
module mmd_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic div_o,
  input logic psel_o,
  input logic ppass_o,
  input logic ld_o,
  input logic err_o
);
  a_r3_open_low_at_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_o) |-> !psel_o);

  a_r6_edge_after_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ppass_o) |=> $rose(div_o));

  a_r6_pass_ends_div5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(psel_o) |-> $fell(ppass_o));

  a_r7_out_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_o) |=> div_o);

  a_r8_ld_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_o |=> !ld_o);

  a_r9_err_on_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(err_o) |-> $past(ld_o));
endmodule

bind mmd_ctrl mmd_ctrl_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .div_o  (div_o),
  .psel_o (psel_o),
  .ppass_o(ppass_o),
  .ld_o   (ld_o),
  .err_o  (err_o)
);

// File: tb/mmd_ctrl_tb_top.sv
module mmd_ctrl_tb_top;
  localparam int MOD_W   = 7;
  localparam int N_EDGES = 300;
  localparam int LIMIT   = 150000;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [MOD_W-1:0] mod_i = MOD_W'(20);
  logic             div_o, psel_o, ppass_o, ld_o, err_o;

  int total = 0;
  int bad   = 0;

  always #10 clk_i = ~clk_i;

  mmd_ctrl #(.MOD_W(MOD_W), .LOAD_DLY(15)) dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mod_i  (mod_i),
    .div_o  (div_o),
    .psel_o (psel_o),
    .ppass_o(ppass_o),
    .ld_o   (ld_o),
    .err_o  (err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_len(input int v);
    int d, q, r;
    if (v < 20) return 20;
    d = v - 20; q = d / 4; r = d % 4;
    if (q < r) return 20 + 5 * q;
    return v;
  endfunction

  function automatic int eff_err(input int v);
    int d;
    if (v < 20) return 1;
    d = v - 20;
    return ((d / 4) < (d % 4)) ? 1 : 0;
  endfunction

  initial begin
    int cyc = 0, last_edge = 0, edges = 0;
    int psel_n = 0, pass_n = 0, hi_n = 0, ld_n = 0, ld_off = -1;
    int exp_len = 20, exp_m5 = 0, exp_err = 0, v = 20, off;
    bit have_edge = 0, early = 0, prev_div = 0, rise;
    logic [15:0] lfsr = 16'hACE1;

    repeat (3) @(negedge clk_i);
    // R1: reset values
    chk(div_o == 0 && psel_o == 0 && ppass_o == 0, "R1 outs in reset",
        {29'd0, div_o, psel_o, ppass_o}, 0);
    chk(ld_o == 0 && err_o == 0, "R1 ld/err in reset", {30'd0, ld_o, err_o}, 0);
    rst_ni = 1'b1;

    while (edges < N_EDGES && cyc < LIMIT) begin
      @(negedge clk_i);
      cyc++;
      if (cyc == 1) chk(div_o == 0 && err_o == 0 && ld_o == 0, "R1 after release",
                        {29'd0, div_o, err_o, ld_o}, 0);
      rise = div_o && !prev_div;
      prev_div = div_o;
      if (rise) begin
        if (!have_edge) begin
          chk(cyc == 21, "R10 first edge", cyc, 21);
        end else begin
          chk(cyc - last_edge == exp_len, "R5 spacing", cyc - last_edge, exp_len);
          chk(psel_n == 5 * exp_m5, "R4 psel high count", psel_n, 5 * exp_m5);
          chk(cyc - last_edge - psel_n == exp_len - 5 * exp_m5, "R2 low-select cycles",
              cyc - last_edge - psel_n, exp_len - 5 * exp_m5);
          chk(!early, "R3 opening run low", early, 0);
          chk(pass_n == (exp_m5 > 0 ? 5 : 4), "R6 pass width", pass_n,
              exp_m5 > 0 ? 5 : 4);
          chk(hi_n == 4, "R7 output width", hi_n, 4);
          chk(ld_n == 1 && ld_off == 14, "R8 capture strobe", ld_n * 100 + ld_off, 114);
          chk(err_o == exp_err[0], "R9 clamp flag", err_o, exp_err);
        end
        if (edges < 128) v = edges;
        else if (edges < 168) v = (edges % 2) ? 127 : 20;
        else begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          v = int'(lfsr[MOD_W-1:0]);
        end
        mod_i   = MOD_W'(v);
        exp_len = eff_len(v);
        exp_m5  = (exp_len - 20) % 4;
        exp_err = eff_err(v);
        psel_n = 0; pass_n = 0; hi_n = 0; ld_n = 0; ld_off = -1; early = 0;
        have_edge = 1;
        last_edge = cyc;
        edges++;
      end
      off = cyc - last_edge;
      if (psel_o) begin
        psel_n++;
        if (off < 19) early = 1;
      end
      if (ppass_o) pass_n++;
      if (div_o) hi_n++;
      if (ld_o) begin
        ld_n++;
        ld_off = off;
      end
    end

    if (cyc >= LIMIT) chk(0, "watchdog", cyc, LIMIT);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule